// File: doc/BRIEF.md
# Single-Precision to Unsigned 8-bit Float Scale Encoder

This block turns a positive single-precision (FP32) scale factor into an unsigned 8-bit float code with a 4-bit exponent (bias 7) and a 3-bit mantissa. It is meant for quantization pipelines that store one compact scale per group of elements. The encoder rounds to nearest with ties to even and covers both the normal range and the subnormal range of the small format. Values too large for the small format saturate the exponent. Values too small for it flush to zero.

A sample is presented on `inData` with `inValid` high. The code appears on `outCode` one clock later, with `outValid` high. A new sample may be accepted on every cycle. Bit 7 of the code is always 0. Bits 6:3 hold the exponent and bits 2:0 hold the mantissa. A code with exponent 0 decodes as m/8·2^-6. Any other code decodes as (1+m/8)·2^(e-7). Sign, NaN and infinity are not interpreted: the sign bit of the input is ignored.

Top module: `e4m3_enc`

## Requirements
- R1: `outValid` is high exactly one cycle after a cycle with `inValid` high, and low otherwise. `outCode` changes only in the cycle after an accepted sample, so it holds its value while `inValid` is low.
- R2: While reset (`rstN` low) is asserted, `outValid` is 0 and `outCode` is 0x00.
- R3: For FP32 exponent fields 121 to 135, the code exponent is the FP32 exponent field minus 120, and the code mantissa is FP32 bits 22:20 before rounding.
- R4: In the normal range, the mantissa is incremented when FP32 bit 19 is set and either one of bits 18:0 is set or the unrounded mantissa LSB is set. Otherwise it is truncated.
- R5: When rounding carries the mantissa from 7 to 8, the mantissa becomes 0 and the exponent increases by one. This includes the step from the largest subnormal code 0x07 to 0x08.
- R6: For FP32 exponent fields of 136 and above, or when a carry would take the exponent past 15, the code exponent is clamped to 15 while the rounded mantissa is kept.
- R7: For FP32 exponent fields 117 to 120, the code exponent is 0. The code mantissa is the significand with its implicit one, shifted right by 121 minus the exponent field, and taken at the 3-bit window.
- R8: In the subnormal range, rounding uses the bit just below the 3-bit window as guard and all lower bits (including bits shifted out) as sticky, with ties to an even mantissa.
- R9: For FP32 exponent fields 1 to 116, the code is 0x00.
- R10: A zero input or an FP32 subnormal input (exponent field 0) encodes as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks `inData` as a sample to encode |
| inData | input | 32 | FP32 scale value (sign bit ignored) |
| outValid | output | 1 | Marks `outCode` as the result of the sample from the previous cycle |
| outCode | output | 8 | Unsigned 8-bit float code, exponent in bits 6:3, mantissa in bits 2:0 |

## Verification
The sweep covers every exponent from deep underflow to far past saturation. For each exponent it walks the mantissa bits around the guard position, so that exact ties, near-ties and sticky-only tails all appear. Each result is compared with the nearest representable code, found by a real-valued search with ties to even.

- A design that ignored the sticky bit would round true halfway cases up, or would truncate values just above the halfway point.
- A design that left out the carry would wrap 0x0F+1 or 0x07+1 back to a smaller code.
- A design that dropped the bits shifted out on the subnormal path would mis-round near 2^-10.
- A design with an unsaturated shift would produce garbage for tiny inputs.
- Hold checks with `inValid` low catch a register that loads on every cycle.

// File: rtl/e4m3_enc_pkg.sv
package e4m3_enc_pkg;
  // input format
  localparam int IN_EXP_W  = 8;
  localparam int IN_MAN_W  = 23;
  localparam int IN_BIAS   = 127;
  // output format
  localparam int OUT_EXP_W = 4;
  localparam int OUT_MAN_W = 3;
  localparam int OUT_BIAS  = 7;

  localparam int IN_W       = 1 + IN_EXP_W + IN_MAN_W;
  localparam int CODE_W     = 1 + OUT_EXP_W + OUT_MAN_W;
  localparam int REBIAS     = IN_BIAS - OUT_BIAS;
  localparam int DROP       = IN_MAN_W - OUT_MAN_W;      // mantissa bits removed
  localparam int SIG_W      = IN_MAN_W + 1;              // with implicit one
  localparam int SHIFT_CAP  = OUT_MAN_W + 2;             // beyond this: all zero
  localparam int SH_W       = $clog2(SHIFT_CAP + 1);
  localparam int WIDE_W     = SIG_W + SHIFT_CAP;
  localparam int EXP_CALC_W = IN_EXP_W + 2;
  localparam int EXP_MAX    = (1 << OUT_EXP_W) - 1;
  localparam int UNDER_LIM  = REBIAS + 1 - SHIFT_CAP;    // field at or below: zero
  localparam int SAT_LIM    = REBIAS + EXP_MAX;          // field above: clamped

  typedef struct packed {
    logic load;   // capture the converted code this cycle
  } ctrl_t;
endpackage

// File: rtl/e4m3_enc_round.sv
module e4m3_enc_round
  import e4m3_enc_pkg::*;
(
  input  logic [OUT_MAN_W-1:0] manIn,
  input  logic                 guardBit,
  input  logic                 stickyBit,
  output logic [OUT_MAN_W-1:0] manOut,
  output logic                 carryOut
);
  logic               roundUp;
  logic [OUT_MAN_W:0] manSum;

  always_comb begin
    roundUp  = guardBit & (stickyBit | manIn[0]);
    manSum   = {1'b0, manIn} + {{OUT_MAN_W{1'b0}}, roundUp};
    carryOut = manSum[OUT_MAN_W];
    manOut   = manSum[OUT_MAN_W-1:0];  // zero when the sum wrapped
  end
endmodule

// File: rtl/e4m3_enc_datapath.sv
module e4m3_enc_datapath
  import e4m3_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [IN_W-1:0]   inData,
  output logic [CODE_W-1:0] codeQ
);
  logic [IN_EXP_W-1:0]          expField;
  logic [IN_MAN_W-1:0]          manField;
  logic signed [EXP_CALC_W-1:0] expRaw;
  logic signed [EXP_CALC_W-1:0] shiftFull;
  logic signed [EXP_CALC_W-1:0] expSum;
  logic                         isNormal;
  logic [SH_W-1:0]              shiftSat;
  logic [WIDE_W-1:0]            wideSig;
  logic [OUT_MAN_W-1:0]         manPick, manRnd;
  logic                         guardPick, stickyPick, carry;
  logic [OUT_EXP_W-1:0]         expFinal;

  assign expField = inData[IN_W-2 -: IN_EXP_W];
  assign manField = inData[IN_MAN_W-1:0];

  always_comb begin
    expRaw    = $signed({2'b00, expField}) - $signed(EXP_CALC_W'(REBIAS));
    isNormal  = !expRaw[EXP_CALC_W-1] && (expRaw != '0);
    shiftFull = $signed(EXP_CALC_W'(1)) - expRaw;
    if (isNormal)
      shiftSat = '0;
    else if (shiftFull >= $signed(EXP_CALC_W'(SHIFT_CAP)))
      shiftSat = SH_W'(SHIFT_CAP);
    else
      shiftSat = shiftFull[SH_W-1:0];
    wideSig = {1'b1, manField, {SHIFT_CAP{1'b0}}} >> shiftSat;
  end

  // Normal path reads the raw mantissa, subnormal path the shifted significand.
  always_comb begin
    if (isNormal) begin
      manPick    = manField[IN_MAN_W-1 -: OUT_MAN_W];
      guardPick  = manField[DROP-1];
      stickyPick = |manField[DROP-2:0];
    end else begin
      manPick    = wideSig[SHIFT_CAP+DROP +: OUT_MAN_W];
      guardPick  = wideSig[SHIFT_CAP+DROP-1];
      stickyPick = |wideSig[SHIFT_CAP+DROP-2:0];
    end
  end

  e4m3_enc_round u_round (
    .manIn    (manPick),
    .guardBit (guardPick),
    .stickyBit(stickyPick),
    .manOut   (manRnd),
    .carryOut (carry)
  );

  always_comb begin
    expSum = (isNormal ? expRaw : '0) + $signed({{(EXP_CALC_W-1){1'b0}}, carry});
    if (expSum > $signed(EXP_CALC_W'(EXP_MAX)))
      expFinal = OUT_EXP_W'(EXP_MAX);
    else
      expFinal = expSum[OUT_EXP_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          codeQ <= '0;
    else if (ctrl.load) codeQ <= {1'b0, expFinal, manRnd};
  end

  a_r1_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(codeQ));
  a_r10_zero_field: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load && (expField == '0) |=> codeQ == '0);
  a_r9_deep_underflow: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load && (expField <= IN_EXP_W'(UNDER_LIM)) |=> codeQ == '0);
  a_r6_exp_saturate: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load && (expField > IN_EXP_W'(SAT_LIM))
    |=> codeQ[CODE_W-2 -: OUT_EXP_W] == OUT_EXP_W'(EXP_MAX));
endmodule

// File: rtl/e4m3_enc_ctrl.sv
module e4m3_enc_ctrl
  import e4m3_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t ctrl,
  output logic  outValid
);
  always_comb ctrl.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/e4m3_enc.sv
module e4m3_enc
  import e4m3_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inData,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode
);
  ctrl_t ctrl;

  e4m3_enc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  e4m3_enc_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .inData(inData),
    .codeQ (outCode)
  );
endmodule

// File: tb/e4m3_enc_tb.sv
`timescale 1ns/1ps
module e4m3_enc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        outValid;
  logic [7:0]  outCode;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  e4m3_enc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outCode(outCode)
  );

  function automatic real codeValue(int c);
    int e = c >> 3;
    int m = c & 7;
    if (c == 128) return 512.0;
    if (e == 0) return (m / 8.0) * (2.0 ** -6);
    return (1.0 + m / 8.0) * (2.0 ** (e - 7));
  endfunction

  // Nearest code with ties to even; beyond-range fields clamp the exponent.
  function automatic logic [7:0] refCode(logic [31:0] x);
    int  e = int'(x[30:23]);
    real v, d, bestD;
    int  best = 0;
    if (e >= 136) begin
      int m = int'(x[22:20]);
      if (x[19] && ((x[18:0] != 0) || (m % 2 == 1))) m = m + 1;
      if (m == 8) m = 0;
      return {1'b0, 4'hF, 3'(m)};
    end
    if (e == 0) v = real'(x[22:0]) * (2.0 ** -149);
    else        v = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    bestD = 1.0e30;
    for (int c = 0; c <= 128; c++) begin
      d = v - codeValue(c);
      if (d < 0.0) d = -d;
      if (d < bestD || (d == bestD && (c % 2 == 0))) begin
        bestD = d;
        best = c;
      end
    end
    return (best == 128) ? 8'h78 : 8'(best);
  endfunction

  function automatic string reqTag(logic [31:0] x);
    int e = int'(x[30:23]);
    if (e == 0)   return "R10";
    if (e <= 116) return "R9";
    if (e <= 120) return "R7/R8/R5";
    if (e <= 135) return "R3/R4/R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] x);
    logic [7:0] exp = refCode(x);
    @(negedge clk);
    inData  = x;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R1 valid", int'(outValid), 1);
    check(outCode == exp, reqTag(x), int'(outCode), int'(exp));
  endtask

  task automatic holdCheck();
    logic [7:0] prev = outCode;
    inData = ~inData;
    @(negedge clk);
    check(outValid == 1'b0, "R1 idle valid", int'(outValid), 0);
    check(outCode == prev, "R1 hold", int'(outCode), int'(prev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cnt = 0;
    logic [31:0] lows [4] = '{32'h0, 32'h1, 32'h1FFFF, 32'hAAAA};
    // R2: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R2 valid", int'(outValid), 0);
    check(outCode == 8'h00, "R2 code", int'(outCode), 0);
    rstN = 1'b1;

    // R10: zero and FP32 subnormals
    apply(32'h0000_0000);
    apply(32'h0000_0001);
    apply(32'h007F_FFFF);
    // R3 exact value 1.0 -> 0x38; R5 carry 0x3F7FFFFF ~1.0 from below; R6 big
    apply(32'h3F80_0000);
    apply(32'h3F7F_FFFF);
    apply(32'h7F7F_FFFF);
    apply(32'hFF80_0000);
    // R8 tie at 2^-10 flushes to 0; just above rounds to 0x01
    apply(32'h3A80_0000);
    apply(32'h3A80_0001);

    // Sweep exponents and the mantissa bits around the guard position.
    for (int e = 100; e <= 150; e++) begin
      for (int hi = 0; hi < 64; hi++) begin
        for (int k = 0; k < 4; k++) begin
          apply({1'b0, 8'(e), 6'(hi), lows[k][16:0]});
          cnt++;
          if (cnt % 97 == 0) holdCheck();
        end
      end
    end

    // R1: back-to-back samples
    @(negedge clk);
    inData = 32'h3F80_0000; inValid = 1'b1;
    @(negedge clk);
    check(outCode == 8'h38, "R1 burst first", int'(outCode), 8'h38);
    inData = 32'h4000_0000;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1 && outCode == 8'h40, "R1 burst second", int'(outCode), 8'h40);
    @(negedge clk);
    check(outValid == 1'b0, "R1 burst end", int'(outValid), 0);

    doneFlag = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule